// File: doc/BRIEF.md
# Dual Interval Timer with Reload

This block holds two 16-bit down-counters for a peripheral adapter. A processor reaches them through an 8-bit register port, one byte per access: low bytes go into holding latches and a write of a high byte loads the full counter and starts it. Both counters step on a single-cycle tick strobe derived from a slow bus clock. The first timer can also step its counter on every tick and reload from its latch at each expiry. The second timer can instead count falling edges on an external pulse input.

The first timer can flip a square-wave output pin on each expiry. Each timer drives an expiry flag for an interrupt block outside this one. Some register accesses change state as well as moving data: starting a timer clears its flag, and reading a timer's low counter byte clears that flag. The auxiliary control register holds the mode bits.

Top module: `dtmr_top`

## Requirements
- R1: After reset, both counters, all latches, all mode bits and both flags are zero, and `sq_out` is 0. Every register reads 0.
- R2: Writes to address 4 or address 6 store the timer-1 low latch. A write to address 7 stores the timer-1 high latch and leaves the counter and flag unchanged. Reads of 6 and 7 return the low and high latch bytes.
- R3: A write to address 5 stores the high latch and loads the counter with {written byte, low latch}. It also arms the one-shot and clears the timer-1 flag. This write takes priority over a tick in the same cycle. Reads of 4 and 5 return the counter's low and high bytes.
- R4: A tick that finds the timer-1 counter at zero is an expiry. Every other tick decrements the counter by 1. After a start with value N, the flag rises with the (N+1)th tick.
- R5: In one-shot mode (auxiliary bit 6 = 0), the flag is set at most once per start. At expiry the counter wraps to all ones and keeps decrementing.
- R6: In continuous mode (auxiliary bit 6 = 1), every expiry sets the flag and reloads the counter from the latch. The flag therefore repeats every N+1 ticks.
- R7: With auxiliary bit 7 = 1, `sq_out` inverts on each expiry that sets the timer-1 flag. In one-shot mode only the first expiry after a start inverts it. With bit 7 = 0, `sq_out` never changes.
- R8: A read of address 4 clears the timer-1 flag. If an expiry falls in the same cycle, the flag ends up set.
- R9: A write to address 8 stores the timer-2 low latch. A write to address 9 loads the timer-2 counter with {written byte, low latch}, arms it and clears the timer-2 flag. Reads of 8 and 9 return the counter bytes, and a read of 8 clears the timer-2 flag.
- R10: With auxiliary bit 5 = 0, timer 2 steps on ticks as a one-shot. The flag rises on the (N+1)th tick after a start and is not set again before the next start.
- R11: With auxiliary bit 5 = 1, timer 2 steps once per falling edge of `pulse_in`, seen after a two-flop synchronizer, and ignores ticks. The flag rises on the (N+1)th falling edge.
- R12: Address 11 holds auxiliary bits 7, 6 and 5, and its other bits read 0. Addresses other than 4 to 9 and 11 read 0.
- R13: Without a tick, the timer-1 counter holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Single-cycle count strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not reading) |
| pulse_in | input | 1 | Asynchronous pulse input for timer-2 counting |
| sq_out | output | 1 | Timer-1 square-wave output |
| t1_flag | output | 1 | Timer-1 expiry flag |
| t2_flag | output | 1 | Timer-2 expiry flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes, which give 16-bit counters, and a two-stage synchronizer. Load values are drawn from a small range. This keeps each expiry, each continuous reload period and the one-shot wrap to 0xFFFF within a few dozen ticks. The same cycles are long enough to show a second expiry not firing. With only two synchronizer stages, a pulse of four cycles low and four high is enough for each falling edge to be counted before the next one arrives.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    // Register select codes decoded by the shell
    localparam logic [3:0] RS_T1_CLO = 4'd4;
    localparam logic [3:0] RS_T1_CHI = 4'd5;
    localparam logic [3:0] RS_T1_LLO = 4'd6;
    localparam logic [3:0] RS_T1_LHI = 4'd7;
    localparam logic [3:0] RS_T2_CLO = 4'd8;
    localparam logic [3:0] RS_T2_CHI = 4'd9;
    localparam logic [3:0] RS_AUX    = 4'd11;

    typedef struct packed {
        logic sq_en;     // invert square output on timer-1 expiry
        logic t1_cont;   // timer-1 reload mode
        logic t2_pulse;  // timer-2 counts input edges
    } aux_t;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic start;
        logic rd_clr;
    } t1_ctl_t;

    typedef struct packed {
        logic lo_wr;
        logic start;
        logic rd_clr;
    } t2_ctl_t;
endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    // sh[0..STAGES-1] synchronizer, sh[STAGES] previous synchronized value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/dtmr_t1.sv
module dtmr_t1 import dtmr_pkg::*; #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  t1_ctl_t                 ctl,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic                    cont,
    input  logic                    sq_en,
    output logic [2*BYTE_W-1:0]     cnt_o,
    output logic [2*BYTE_W-1:0]     lat_o,
    output logic                    flag_o,
    output logic                    sq_o
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lat;
        logic             flag;
        logic             armed;
        logic             sq;
    } t1_st_t;

    t1_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.lo_wr) st_d.lat[BYTE_W-1:0]     = wdata;
        if (ctl.hi_wr) st_d.lat[CNT_W-1:BYTE_W] = wdata;
        if (ctl.rd_clr) st_d.flag = 1'b0;
        if (ctl.start) begin
            st_d.lat[CNT_W-1:BYTE_W] = wdata;
            st_d.cnt   = {wdata, st_q.lat[BYTE_W-1:0]};
            st_d.armed = 1'b1;
            st_d.flag  = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                if (cont || st_q.armed) begin
                    st_d.flag = 1'b1;
                    if (sq_en) st_d.sq = ~st_q.sq;
                end
                if (cont) begin
                    st_d.cnt = st_q.lat;
                end else begin
                    st_d.cnt   = st_q.cnt - 1'b1;
                    st_d.armed = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign lat_o  = st_q.lat;
    assign flag_o = st_q.flag;
    assign sq_o   = st_q.sq;
endmodule

// File: rtl/dtmr_t2.sv
module dtmr_t2 import dtmr_pkg::*; #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec,
    input  t2_ctl_t                 ctl,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [2*BYTE_W-1:0]     cnt_o,
    output logic                    flag_o
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] lat_lo;
        logic              flag;
        logic              armed;
    } t2_st_t;

    t2_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.lo_wr)  st_d.lat_lo = wdata;
        if (ctl.rd_clr) st_d.flag   = 1'b0;
        if (ctl.start) begin
            st_d.cnt   = {wdata, st_q.lat_lo};
            st_d.armed = 1'b1;
            st_d.flag  = 1'b0;
        end else if (dec) begin
            if (st_q.cnt == '0 && st_q.armed) begin
                st_d.flag  = 1'b1;
                st_d.armed = 1'b0;
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top import dtmr_pkg::*; #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              pulse_in,
    output logic              sq_out,
    output logic              t1_flag,
    output logic              t2_flag
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic             wr_en, rd_en;
    t1_ctl_t          t1_ctl;
    t2_ctl_t          t2_ctl;
    aux_t             aux_d, aux_q;
    logic [CNT_W-1:0] t1_cnt, t1_lat, t2_cnt;
    logic             pin_fall, t2_dec;

    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;

    always_comb begin
        t1_ctl.lo_wr  = wr_en && (bus_addr == RS_T1_CLO || bus_addr == RS_T1_LLO);
        t1_ctl.hi_wr  = wr_en && (bus_addr == RS_T1_LHI);
        t1_ctl.start  = wr_en && (bus_addr == RS_T1_CHI);
        t1_ctl.rd_clr = rd_en && (bus_addr == RS_T1_CLO);
        t2_ctl.lo_wr  = wr_en && (bus_addr == RS_T2_CLO);
        t2_ctl.start  = wr_en && (bus_addr == RS_T2_CHI);
        t2_ctl.rd_clr = rd_en && (bus_addr == RS_T2_CLO);
    end

    always_comb begin
        aux_d = aux_q;
        if (wr_en && bus_addr == RS_AUX) begin
            aux_d.sq_en    = bus_wdata[7];
            aux_d.t1_cont  = bus_wdata[6];
            aux_d.t2_pulse = bus_wdata[5];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    dtmr_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .din(pulse_in), .fall_o(pin_fall)
    );

    assign t2_dec = aux_q.t2_pulse ? pin_fall : tick_en;

    dtmr_t1 #(.BYTE_W(BYTE_W)) t1_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .ctl(t1_ctl),
        .wdata(bus_wdata), .cont(aux_q.t1_cont), .sq_en(aux_q.sq_en),
        .cnt_o(t1_cnt), .lat_o(t1_lat), .flag_o(t1_flag), .sq_o(sq_out)
    );

    dtmr_t2 #(.BYTE_W(BYTE_W)) t2_i (
        .clk(clk), .rst_n(rst_n), .dec(t2_dec), .ctl(t2_ctl),
        .wdata(bus_wdata), .cnt_o(t2_cnt), .flag_o(t2_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                RS_T1_CLO: bus_rdata = t1_cnt[BYTE_W-1:0];
                RS_T1_CHI: bus_rdata = t1_cnt[CNT_W-1:BYTE_W];
                RS_T1_LLO: bus_rdata = t1_lat[BYTE_W-1:0];
                RS_T1_LHI: bus_rdata = t1_lat[CNT_W-1:BYTE_W];
                RS_T2_CLO: bus_rdata = t2_cnt[BYTE_W-1:0];
                RS_T2_CHI: bus_rdata = t2_cnt[CNT_W-1:BYTE_W];
                RS_AUX: begin
                    bus_rdata[7] = aux_q.sq_en;
                    bus_rdata[6] = aux_q.t1_cont;
                    bus_rdata[5] = aux_q.t2_pulse;
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [3:0]          bus_addr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [2*BYTE_W-1:0] t1_cnt,
    input logic [2*BYTE_W-1:0] t1_lat,
    input logic                t2_dec,
    input logic                sq_en,
    input logic                t1_flag,
    input logic                t2_flag,
    input logic                sq_out
);
    logic wr5, wr7, rd4;
    assign wr5 = bus_sel && bus_we && bus_addr == 4'd5;
    assign wr7 = bus_sel && bus_we && bus_addr == 4'd7;
    assign rd4 = bus_sel && !bus_we && bus_addr == 4'd4;

    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr5 |=> t1_cnt == {$past(bus_wdata), $past(t1_lat[BYTE_W-1:0])}); // R3
    AST_T1_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr5 |=> !t1_flag); // R3
    AST_LATCH_HI_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr7 && !tick_en |=> t1_cnt == $past(t1_cnt)); // R2
    AST_T1_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t1_flag) |-> $past(tick_en)); // R4
    AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !bus_sel |=> $stable(t1_cnt)); // R13
    AST_SQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sq_out) |-> $past(tick_en) && $past(sq_en)); // R7
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd4 && !tick_en |=> !t1_flag); // R8
    AST_T2_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t2_flag) |-> $past(t2_dec)); // R10
endmodule

bind dtmr_top dtmr_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .t1_cnt(t1_cnt), .t1_lat(t1_lat), .t2_dec(t2_dec), .sq_en(aux_q.sq_en),
    .t1_flag(t1_flag), .t2_flag(t2_flag), .sq_out(sq_out)
);

// File: tb/dtmr_top_tb_top.sv
module dtmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pulse_in = 1'b1;
    logic       sq_out, t1_flag, t2_flag;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    dtmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pulse_in(pulse_in), .sq_out(sq_out),
        .t1_flag(t1_flag), .t2_flag(t2_flag)
    );

    function automatic logic [15:0] exp_cnt(input int unsigned n, input int unsigned k);
        return 16'((n - k) & 32'hFFFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] lo_a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(lo_a + 4'd1, h);
        rd(lo_a, l);
        v = {h, l};
    endtask

    task automatic ticks(input int unsigned n);
        for (int i = 0; i < int'(n); i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(posedge clk); #1; tick_en = 1'b0;
        end
    endtask

    task automatic pulses(input int unsigned n);
        for (int i = 0; i < int'(n); i++) begin
            @(negedge clk); pulse_in = 1'b0;
            repeat (4) @(negedge clk);
            pulse_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic        sq_exp;
        void'($urandom(32'h5eed));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 t1_flag", t1_flag, 0);
        chk("R1 t2_flag", t2_flag, 0);
        chk("R1 sq_out", sq_out, 0);
        for (int a = 4; a <= 11; a++) begin
            rd(4'(a), b);
            chk("R1 register", b, 0);
        end

        // R12 auxiliary register and unused addresses
        wr(4'd11, 8'hFF);
        rd(4'd11, b); chk("R12 aux readback", b, 8'hE0);
        rd(4'd10, b); chk("R12 unused addr", b, 0);
        rd(4'd13, b); chk("R12 unused addr", b, 0);
        wr(4'd11, 8'h00);

        // R2 latch writes without start
        wr(4'd6, 8'hAA);
        wr(4'd7, 8'hBB);
        rd(4'd6, b); chk("R2 low latch", b, 8'hAA);
        rd(4'd7, b); chk("R2 high latch", b, 8'hBB);
        rd16(4'd4, v); chk("R2 counter untouched", v, 0);
        chk("R2 flag untouched", t1_flag, 0);
        wr(4'd4, 8'hCC);
        rd(4'd6, b); chk("R2 addr4 writes latch", b, 8'hCC);

        // R3 start
        wr(4'd5, 8'h12);
        rd16(4'd4, v); chk("R3 counter load", v, 16'h12CC);
        rd(4'd7, b); chk("R3 high latch", b, 8'h12);

        // R13 hold without tick
        repeat (6) @(negedge clk);
        rd16(4'd4, v); chk("R13 hold", v, 16'h12CC);

        // R4 R5 one-shot, random loads
        for (int it = 0; it < 6; it++) begin
            int unsigned n;
            n = $urandom_range(0, 30);
            wr(4'd4, 8'(n));
            wr(4'd5, 8'h00);
            ticks(n);
            chk("R4 no flag before expiry", t1_flag, 0);
            ticks(1);
            chk("R4 flag at expiry", t1_flag, 1);
            rd16(4'd4, v); chk("R5 wrap", v, 16'hFFFF);
            chk("R8 read clears", t1_flag, 0);
            ticks(n + 3);
            chk("R5 no second flag", t1_flag, 0);
            rd16(4'd4, v); chk("R5 keeps counting", v, exp_cnt(n, 2 * n + 4));
            chk("R7 sq idle when disabled", sq_out, 0);
        end

        // R6 R7 continuous with square output
        wr(4'd11, 8'hC0);
        sq_exp = 1'b0;
        for (int it = 0; it < 3; it++) begin
            int unsigned n;
            n = $urandom_range(1, 20);
            wr(4'd6, 8'(n));
            wr(4'd7, 8'h00);
            wr(4'd5, 8'h00);
            for (int rep = 0; rep < 2; rep++) begin
                ticks(n);
                chk("R6 no flag early", t1_flag, 0);
                ticks(1);
                sq_exp = ~sq_exp;
                chk("R6 periodic flag", t1_flag, 1);
                chk("R7 sq toggles", sq_out, sq_exp);
                rd16(4'd4, v); chk("R6 reload", v, 16'(n));
            end
        end

        // R7 one-shot toggles once
        wr(4'd11, 8'h80);
        wr(4'd4, 8'd2);
        wr(4'd5, 8'h00);
        ticks(3);
        sq_exp = ~sq_exp;
        chk("R7 one-shot toggle", sq_out, sq_exp);
        ticks(10);
        chk("R7 no second toggle", sq_out, sq_exp);

        // R8 read-clear versus expiry in the same cycle
        wr(4'd11, 8'h40);
        wr(4'd6, 8'h00);
        wr(4'd5, 8'h00);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'd4;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_sel = 1'b0;
        chk("R8 expiry wins over read clear", t1_flag, 1);
        rd(4'd4, b);
        chk("R8 read clears", t1_flag, 0);

        // R3 start wins over tick in the same cycle
        wr(4'd11, 8'h00);
        wr(4'd4, 8'h05);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 8'h00;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd16(4'd4, v); chk("R3 start beats tick", v, 16'h0005);

        // R9 R10 timer 2 timed one-shot
        for (int it = 0; it < 4; it++) begin
            int unsigned n;
            n = $urandom_range(0, 25);
            wr(4'd8, 8'(n));
            wr(4'd9, 8'h00);
            rd16(4'd8, v); chk("R9 t2 load", v, 16'(n));
            ticks(n);
            chk("R10 no flag early", t2_flag, 0);
            ticks(1);
            chk("R10 flag at expiry", t2_flag, 1);
            ticks(5);
            rd16(4'd8, v); chk("R10 wrap and count", v, exp_cnt(n, n + 6));
            chk("R9 read clears t2", t2_flag, 0);
            ticks(3);
            chk("R10 no second flag", t2_flag, 0);
        end

        // R9 start clears flag
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        ticks(1);
        chk("R10 flag", t2_flag, 1);
        wr(4'd9, 8'h01);
        chk("R9 start clears t2", t2_flag, 0);

        // R11 pulse counting
        wr(4'd11, 8'h20);
        for (int it = 0; it < 2; it++) begin
            int unsigned n;
            n = $urandom_range(2, 8);
            wr(4'd8, 8'(n));
            wr(4'd9, 8'h00);
            ticks(4);
            rd16(4'd8, v); chk("R11 ticks ignored", v, 16'(n));
            pulses(n);
            chk("R11 no flag early", t2_flag, 0);
            rd16(4'd8, v); chk("R11 edge count", v, 16'h0000);
            pulses(1);
            chk("R11 flag on last edge", t2_flag, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule